// File: doc/BRIEF.md
# Secondary Interrupt Controller with Per-Line Pass-Through

This block gathers 32 level-sensitive interrupt sources and presents them to a primary interrupt controller through 32 output lines. Enabled sources are ORed into a single combined request on the highest output line. Any of sources 21 through 30 can also be routed individually to its own output line, so the primary controller sees it directly rather than through the combined request.

Software reaches the block through a word-addressed register window. Accesses are single-cycle: valid, write, a byte address and 32-bit write data, with read data returned on the next cycle. The window holds raw and masked status views, set and clear ports for the enable mask and for the pass-through enables, and a latched software interrupt that appears as source 0. The outputs are registered. Status reads show the input levels sampled on the previous clock edge.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After reset the enable mask, the pass-through enables and the software flag are zero, all 32 outputs are low, and reads of index 2, 4 and 8 return zero.
- R2: A write to index 2 ORs the write data into the enable mask, a write to index 3 clears every mask bit that is set in the write data, and a read of index 2 returns the mask.
- R3: The raw vector is the sampled input levels with the software flag ORed into bit 0. A read of index 1 returns the raw vector and a read of index 0 returns the raw vector ANDed with the mask.
- R4: Output 31 is high exactly when the raw vector ANDed with the mask is nonzero, one clock after the input or write that caused the change.
- R5: A write to index 8 sets pass-through enables only in bits 21..30 (mask 0x7FE00000). A write to index 9 clears the pass-through bits that are set in the write data. A read of index 8 returns the pass-through enables.
- R6: Output i (0 to 30) equals raw bit i when pass-through bit i is set and is low otherwise, so outputs 0..20 are always low.
- R7: A nonzero write to index 4 sets the software flag, a nonzero write to index 5 clears it, and a zero write to either has no effect. A read of index 4 returns raw bit 0 in bit 0 and zeros above.
- R8: Reads of indices other than 0, 1, 2, 4 and 8 return zero. Writes to indices other than 2, 3, 4, 5, 8 and 9 change no state.
- R9: The register index is the byte address divided by 4. Read data appears on the cycle after the read request and is zero on any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regValid | input | 1 | Register access request this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte address; the index is bits 11:2 |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after a read |
| irqIn | input | 32 | Level-sensitive interrupt sources |
| irqOut | output | 32 | Lines to the primary controller; bit 31 is the combined request |

## Verification
On every cycle the assertions check that outputs 0..20 stay low, that pass-through reads never show a bit outside 21..30, that unmapped and idle cycles return zero read data, that a software-flag read carries only bit 0, and that clearing the whole mask drops the combined request. The scenarios show what a property cannot follow without a copy of the state: set/clear accumulation in the mask, pass-through lines tracking changing inputs, the software flag reaching output 31 through the mask, and ignored writes leaving the mask and the pass-through enables unchanged. A behavioural model compared on every clock covers mixed random traffic.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;

  // Register indices (byte address / 4); software depends on these values.
  localparam int IDX_STATUS  = 0;
  localparam int IDX_RAW     = 1;
  localparam int IDX_EN_SET  = 2;
  localparam int IDX_EN_CLR  = 3;
  localparam int IDX_SW_SET  = 4;
  localparam int IDX_SW_CLR  = 5;
  localparam int IDX_PT_SET  = 8;
  localparam int IDX_PT_CLR  = 9;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_RAW,
    RD_MASK,
    RD_SOFT,
    RD_PASS
  } rd_sel_t;

  typedef struct packed {
    logic    maskSet;
    logic    maskClr;
    logic    swSet;
    logic    swClr;
    logic    passSet;
    logic    passClr;
    rd_sel_t rdSel;
  } strobe_t;

endpackage

// File: rtl/sec_irq_regs.sv
module sec_irq_regs
  import sec_irq_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] regWdata,
  output strobe_t           stb
);

  localparam logic [IDX_W-1:0] I_STATUS = IDX_W'(IDX_STATUS);
  localparam logic [IDX_W-1:0] I_RAW    = IDX_W'(IDX_RAW);
  localparam logic [IDX_W-1:0] I_EN_SET = IDX_W'(IDX_EN_SET);
  localparam logic [IDX_W-1:0] I_EN_CLR = IDX_W'(IDX_EN_CLR);
  localparam logic [IDX_W-1:0] I_SW_SET = IDX_W'(IDX_SW_SET);
  localparam logic [IDX_W-1:0] I_SW_CLR = IDX_W'(IDX_SW_CLR);
  localparam logic [IDX_W-1:0] I_PT_SET = IDX_W'(IDX_PT_SET);
  localparam logic [IDX_W-1:0] I_PT_CLR = IDX_W'(IDX_PT_CLR);

  logic wrReq;
  logic rdReq;
  logic dataNonZero;

  assign wrReq       = regValid & regWrite;
  assign rdReq       = regValid & ~regWrite;
  assign dataNonZero = |regWdata;

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    if (wrReq) begin
      case (regIdx)
        I_EN_SET: stb.maskSet = 1'b1;
        I_EN_CLR: stb.maskClr = 1'b1;
        I_SW_SET: stb.swSet   = dataNonZero;
        I_SW_CLR: stb.swClr   = dataNonZero;
        I_PT_SET: stb.passSet = 1'b1;
        I_PT_CLR: stb.passClr = 1'b1;
        default:  ;
      endcase
    end
    if (rdReq) begin
      case (regIdx)
        I_STATUS: stb.rdSel = RD_STATUS;
        I_RAW:    stb.rdSel = RD_RAW;
        I_EN_SET: stb.rdSel = RD_MASK;
        I_SW_SET: stb.rdSel = RD_SOFT;
        I_PT_SET: stb.rdSel = RD_PASS;
        default:  stb.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sec_irq_core.sv
module sec_irq_core
  import sec_irq_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter int PASS_LO   = 21,
  parameter int PASS_HI   = 30,
  parameter int COMB_LINE = 31
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] irqIn,
  output logic [NSRC-1:0] irqOut,
  output logic [NSRC-1:0] rdData
);

  function automatic logic [NSRC-1:0] passRange();
    logic [NSRC-1:0] m;
    for (int i = 0; i < NSRC; i++) begin
      m[i] = (i >= PASS_LO) && (i <= PASS_HI);
    end
    return m;
  endfunction

  localparam logic [NSRC-1:0] PASS_MASK = passRange();
  localparam logic [NSRC-1:0] SW_BIT    = NSRC'(1);

  logic [NSRC-1:0] levelQ, maskQ, passQ;
  logic            swQ;
  logic [NSRC-1:0] maskD, passD, rawD, rawQ, outD, rdD;
  logic            swD;

  // Next-state of the software-visible registers.
  always_comb begin
    maskD = maskQ;
    if (stb.maskSet) maskD = maskD | wdata;
    if (stb.maskClr) maskD = maskD & ~wdata;
    passD = passQ;
    if (stb.passSet) passD = passD | (wdata & PASS_MASK);
    if (stb.passClr) passD = passD & ~wdata;
    swD = swQ;
    if (stb.swSet) swD = 1'b1;
    if (stb.swClr) swD = 1'b0;
  end

  assign rawD = irqIn | (swD ? SW_BIT : '0);
  assign rawQ = levelQ | (swQ ? SW_BIT : '0);

  // Output lines: one combined request, the rest pass-through candidates.
  for (genvar g = 0; g < NSRC; g++) begin : g_line
    if (g == COMB_LINE) begin : g_comb
      assign outD[g] = |(rawD & maskD);
    end else begin : g_pass
      assign outD[g] = passD[g] & rawD[g];
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_STATUS: rdD = rawQ & maskQ;
      RD_RAW:    rdD = rawQ;
      RD_MASK:   rdD = maskQ;
      RD_SOFT:   rdD = rawQ & SW_BIT;
      RD_PASS:   rdD = passQ;
      default:   rdD = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      maskQ  <= '0;
      passQ  <= '0;
      swQ    <= 1'b0;
      irqOut <= '0;
      rdData <= '0;
    end else begin
      levelQ <= irqIn;
      maskQ  <= maskD;
      passQ  <= passD;
      swQ    <= swD;
      irqOut <= outD;
      rdData <= rdD;
    end
  end

endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sec_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12,
  parameter int PASS_LO = 21,
  parameter int PASS_HI = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] regWdata,
  output logic [NUM_SRC-1:0] regRdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [NUM_SRC-1:0] irqOut
);

  localparam int IDX_W     = ADDR_W - 2;
  localparam int COMB_LINE = NUM_SRC - 1;

  strobe_t    stb;
  logic [1:0] unusedAddrLsb;

  assign unusedAddrLsb = regAddr[1:0];

  sec_irq_regs #(
    .IDX_W  (IDX_W),
    .DATA_W (NUM_SRC)
  ) u_regs (
    .regValid (regValid),
    .regWrite (regWrite),
    .regIdx   (regAddr[ADDR_W-1:2]),
    .regWdata (regWdata),
    .stb      (stb)
  );

  sec_irq_core #(
    .NSRC      (NUM_SRC),
    .PASS_LO   (PASS_LO),
    .PASS_HI   (PASS_HI),
    .COMB_LINE (COMB_LINE)
  ) u_core (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wdata  (regWdata),
    .irqIn  (irqIn),
    .irqOut (irqOut),
    .rdData (regRdata)
  );

endmodule

// File: rtl/sec_irq_chk.sv
module sec_irq_chk #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12,
  parameter int PASS_LO = 21,
  parameter int PASS_HI = 30
) (
  input logic               clk,
  input logic               rstN,
  input logic               regValid,
  input logic               regWrite,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [NUM_SRC-1:0] regWdata,
  input logic [NUM_SRC-1:0] regRdata,
  input logic [NUM_SRC-1:0] irqOut
);

  localparam int IDX_W = ADDR_W - 2;

  logic             pastOk;
  logic [IDX_W-1:0] idx;
  logic [1:0]       unusedLsb;
  logic             rdReq, wrReq, mapped;
  logic [NUM_SRC-1:0] outsideRange;

  assign idx       = regAddr[ADDR_W-1:2];
  assign unusedLsb = regAddr[1:0];
  assign rdReq     = regValid && !regWrite;
  assign wrReq     = regValid && regWrite;
  assign mapped    = (idx == 0) || (idx == 1) || (idx == 2) || (idx == 4) || (idx == 8);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) outsideRange[i] = (i < PASS_LO) || (i > PASS_HI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R2: clearing every mask bit removes the combined request
  a_r2_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && wrReq && idx == 3 && regWdata == '1) |=> !irqOut[NUM_SRC-1]);

  // R5: pass-through readback never shows a bit outside the allowed range
  a_r5_pass_range: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && rdReq && idx == 8) |=> ((regRdata & outsideRange) == '0));

  // R6: lines below the pass-through range never assert
  a_r6_low_lines: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> (irqOut[PASS_LO-1:0] == '0));

  // R7: software flag readback carries only bit 0
  a_r7_soft_width: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && rdReq && idx == 4) |=> (regRdata[NUM_SRC-1:1] == '0));

  // R8: unmapped reads return zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && rdReq && !mapped) |=> (regRdata == '0));

  // R9: read data is zero after a cycle with no read
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !rdReq) |=> (regRdata == '0));

endmodule

bind sec_irq_ctrl sec_irq_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .PASS_LO (PASS_LO),
  .PASS_HI (PASS_HI)
) u_chk (.*);

// File: tb/sec_irq_ctrl_test.sv
`timescale 1ns/1ps
module sec_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] irqIn = '0;
  logic [31:0] irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sec_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqIn(irqIn), .irqOut(irqOut)
  );

  // Behavioural reference model
  logic [31:0] mMask, mPass, mLvl, expOut, expRd;
  bit          mSw;

  function automatic logic [31:0] modelRead(int idx, logic [31:0] lvl, bit sw,
                                            logic [31:0] msk, logic [31:0] pt);
    logic [31:0] raw;
    raw = lvl | {31'b0, sw};
    case (idx)
      0: return raw & msk;
      1: return raw;
      2: return msk;
      4: return {31'b0, raw[0]};
      8: return pt;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask = 0; mPass = 0; mLvl = 0; mSw = 0; expOut = 0; expRd = 0;
    end else begin
      int idx;
      logic [31:0] raw;
      idx = int'(regAddr[11:2]);
      if (regValid && !regWrite) expRd = modelRead(idx, mLvl, mSw, mMask, mPass);
      else expRd = 0;
      if (regValid && regWrite) begin
        case (idx)
          2: mMask = mMask | regWdata;
          3: mMask = mMask & ~regWdata;
          4: if (regWdata != 0) mSw = 1;
          5: if (regWdata != 0) mSw = 0;
          8: mPass = mPass | (regWdata & 32'h7FE0_0000);
          9: mPass = mPass & ~regWdata;
          default: ;
        endcase
      end
      mLvl = irqIn;
      raw = mLvl | {31'b0, mSw};
      expOut = mPass & raw;
      expOut[31] = |(raw & mMask);
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (irqOut !== expOut) begin
        errors++;
        $display("FAIL R4,R6 model irqOut actual %h expected %h", irqOut, expOut);
      end
      checks++;
      if (regRdata !== expRd) begin
        errors++;
        $display("FAIL R3,R9 model regRdata actual %h expected %h", regRdata, expRd);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Tasks start at a falling edge and end at one.
  task automatic wr(int idx, logic [31:0] d);
    regValid = 1; regWrite = 1; regAddr = 12'(idx * 4); regWdata = d;
    @(negedge clk);
    regValid = 0; regWrite = 0; regWdata = 0;
  endtask

  task automatic rd(int idx, logic [31:0] exp, string tag);
    regValid = 1; regWrite = 0; regAddr = 12'(idx * 4 + (idx & 3));
    @(negedge clk);
    check(tag, regRdata, exp);
    regValid = 0;
    @(negedge clk);
    check("R9 idle read data", regRdata, 32'h0);
  endtask

  task automatic setIn(logic [31:0] v);
    irqIn = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] nextRand(logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 outputs after reset", irqOut, 32'h0);
    check("R1 read data after reset", regRdata, 32'h0);
    rd(2, 32'h0, "R1 mask reset");
    rd(8, 32'h0, "R1 pass reset");
    rd(4, 32'h0, "R1 soft reset");

    setIn(32'h0000_0010);
    wr(2, 32'h0000_0010);
    check("R4 combined request set", {31'b0, irqOut[31]}, 32'h1);
    rd(0, 32'h0000_0010, "R3 masked status");
    rd(1, 32'h0000_0010, "R3 raw status");

    wr(3, 32'h0000_0010);
    check("R2 clear drops request", {31'b0, irqOut[31]}, 32'h0);
    rd(2, 32'h0, "R2 mask cleared");
    wr(2, 32'hA5A5_0000);
    wr(2, 32'h0000_00F0);
    rd(2, 32'hA5A5_00F0, "R2 mask accumulate");
    check("R4 request via bit 4", {31'b0, irqOut[31]}, 32'h1);
    setIn(32'h0000_0100);
    check("R4 request follows input", {31'b0, irqOut[31]}, 32'h0);

    wr(8, 32'hFFFF_FFFF);
    rd(8, 32'h7FE0_0000, "R5 pass set range");
    setIn(32'h4020_0001);
    check("R6 pass lines", {22'b0, irqOut[30:21]}, 32'h0000_0201);
    check("R6 low lines", {11'b0, irqOut[20:0]}, 32'h0);
    wr(9, 32'h0020_0000);
    rd(8, 32'h7FC0_0000, "R5 pass clear");
    check("R6 disabled line low", {31'b0, irqOut[21]}, 32'h0);
    check("R6 enabled line high", {31'b0, irqOut[30]}, 32'h1);

    wr(3, 32'hFFFF_FFFF);
    setIn(32'h0);
    wr(4, 32'h0);
    rd(4, 32'h0, "R7 zero write ignored");
    wr(4, 32'h0000_0001);
    rd(4, 32'h1, "R7 soft set");
    rd(1, 32'h1, "R7 soft in raw");
    check("R7 masked soft no request", {31'b0, irqOut[31]}, 32'h0);
    wr(2, 32'h0000_0001);
    check("R7 soft reaches request", {31'b0, irqOut[31]}, 32'h1);
    wr(5, 32'h0);
    rd(4, 32'h1, "R7 zero clear ignored");
    wr(5, 32'h8000_0000);
    rd(4, 32'h0, "R7 soft clear");
    check("R7 request drops", {31'b0, irqOut[31]}, 32'h0);

    rd(3, 32'h0, "R8 unmapped 3");
    rd(5, 32'h0, "R8 unmapped 5");
    rd(6, 32'h0, "R8 unmapped 6");
    rd(9, 32'h0, "R8 unmapped 9");
    rd(1023, 32'h0, "R8 unmapped top");
    wr(2, 32'h0000_0F00);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    wr(12, 32'hFFFF_FFFF);
    rd(2, 32'h0000_0F01, "R8 mask untouched");
    rd(8, 32'h7FC0_0000, "R8 pass untouched");
    rd(4, 32'h0, "R8 soft untouched");

    seed = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      int op;
      seed = nextRand(seed);
      irqIn = seed;
      seed = nextRand(seed);
      op = int'(seed[3:0]);
      regValid = (op < 12);
      regWrite = (op < 7);
      regAddr  = {seed[13:12] == 2'b00 ? 6'h01 : 6'h00, seed[7:4] % 4'd10, seed[9:8]};
      seed = nextRand(seed);
      regWdata = seed[0] ? seed : {31'b0, seed[1]};
      @(negedge clk);
    end
    regValid = 0; regWrite = 0;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule